// File: doc/BRIEF.md
# Immediate-Operand Integer ALU

This block executes the immediate-format arithmetic and logic operations of a 32-bit load/store integer pipeline. Each cycle it may be handed a 6-bit primary opcode, the value read from the source register, the 16-bit immediate field of the instruction and the index of the destination register. When the valid strobe is high, the operation is carried out and, on the next clock edge, the block presents a registered result, the destination index and a write enable for the register file.

The immediate is widened in one of three ways, and the opcode picks which. The two additions and both comparisons replicate its sign bit. The bitwise operations pad it with zeros. The upper-load form moves it into the top half of the word. The unsigned comparison still uses the sign-replicated immediate, so a negative immediate acts as a very large unsigned bound. Additions wrap around and never trap. Register 0 is hard-wired to zero, so a write aimed at it is suppressed. An opcode that the block does not implement raises a one-cycle undefined flag and writes nothing.

Top module: `immop_alu`

## Requirements
- R1: Opcodes 8 and 9 produce the 32-bit wraparound sum of the source value and the sign-extended immediate, with no trap or flag on overflow.
- R2: Opcode 10 produces 1 when the source value is less than the sign-extended immediate as two's-complement numbers, and 0 otherwise.
- R3: Opcode 11 produces 1 when the source value is less than the sign-extended immediate with both taken as unsigned 32-bit numbers, and 0 otherwise.
- R4: Opcodes 12, 13 and 14 produce the bitwise AND, OR and XOR, respectively, of the source value and the zero-extended immediate.
- R5: Opcode 15 produces the immediate in bits 31:16 and zeros in bits 15:0, whatever the source value is.
- R6: When the destination index is 0, the write enable stays low even for a defined opcode.
- R7: Any opcode outside 8 to 15 with valid high keeps the write enable low, raises the undefined flag for exactly one cycle and leaves the result and destination outputs unchanged.
- R8: The outputs reflect an operation in the cycle after the clock edge that sampled valid high. In a cycle after an edge that sampled valid low, the write enable and undefined flag are low and the result is unchanged.
- R9: After reset, the result, destination, write enable and undefined flag are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 6 | Primary opcode |
| src_val | input | 32 | Source register value |
| imm_field | input | 16 | Immediate field |
| dst_idx | input | 5 | Destination register index |
| res_q | output | 32 | Registered result |
| dst_q | output | 5 | Registered destination index |
| wr_en_q | output | 1 | Register-file write enable |
| undef_q | output | 1 | Undefined-opcode flag |

## Verification
The bench sweeps all 64 opcodes against source values and immediates placed at the sign boundaries (0x7FFF/0x8000, 0x7FFFFFFF/0x80000000, all ones). A design that zero-extended the immediate for the arithmetic forms, or sign-extended it for the bitwise forms, would give wrong upper halves. A design that compared unsigned against a zero-extended immediate would report 0x80000000 < 0xFFFF8000 as false. Further directed steps check that a write to register 0 is suppressed, that the undefined flag lasts only one cycle and leaves the result alone, and that an idle cycle holds the result.

// File: rtl/immop_pkg.sv
package immop_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;
    localparam int OPC_W  = 6;
    localparam int IDX_W  = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD_S  = 6'd8,
        OP_ADD_W  = 6'd9,
        OP_LT_S   = 6'd10,
        OP_LT_U   = 6'd11,
        OP_AND    = 6'd12,
        OP_OR     = 6'd13,
        OP_XOR    = 6'd14,
        OP_UPPER  = 6'd15
    } imm_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN = 2'd0,
        EXT_ZERO = 2'd1,
        EXT_HIGH = 2'd2
    } ext_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [IDX_W-1:0]  dst;
        logic              wr;
        logic              undef;
    } stage_t;
endpackage

// File: rtl/immop_decode.sv
module immop_decode
    import immop_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic             known,
    output ext_mode_e        ext_mode,
    output imm_op_e          func
);
    always_comb begin
        known    = 1'b1;
        ext_mode = EXT_SIGN;
        func     = OP_ADD_S;
        case (opcode)
            6'd8:  begin func = OP_ADD_S; ext_mode = EXT_SIGN; end
            6'd9:  begin func = OP_ADD_W; ext_mode = EXT_SIGN; end
            6'd10: begin func = OP_LT_S;  ext_mode = EXT_SIGN; end
            6'd11: begin func = OP_LT_U;  ext_mode = EXT_SIGN; end
            6'd12: begin func = OP_AND;   ext_mode = EXT_ZERO; end
            6'd13: begin func = OP_OR;    ext_mode = EXT_ZERO; end
            6'd14: begin func = OP_XOR;   ext_mode = EXT_ZERO; end
            6'd15: begin func = OP_UPPER; ext_mode = EXT_HIGH; end
            default: known = 1'b0;
        endcase
    end
endmodule

// File: rtl/immop_extend.sv
module immop_extend
    import immop_pkg::*;
#(
    parameter int W_IN  = IMM_W,
    parameter int W_OUT = DATA_W
) (
    input  logic [W_IN-1:0]  imm,
    input  ext_mode_e        mode,
    output logic [W_OUT-1:0] wide
);
    localparam int PAD = W_OUT - W_IN;

    always_comb begin
        case (mode)
            EXT_SIGN: wide = {{PAD{imm[W_IN-1]}}, imm};
            EXT_ZERO: wide = {{PAD{1'b0}}, imm};
            EXT_HIGH: wide = W_OUT'(imm) << PAD;
            default:  wide = '0;
        endcase
    end
endmodule

// File: rtl/immop_core.sv
module immop_core
    import immop_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  imm_op_e       func,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y
);
    logic lt_signed;
    logic lt_unsigned;

    assign lt_signed   = $signed(a) < $signed(b);
    assign lt_unsigned = a < b;

    always_comb begin
        case (func)
            OP_ADD_S, OP_ADD_W: y = a + b;
            OP_LT_S:            y = {{(W-1){1'b0}}, lt_signed};
            OP_LT_U:            y = {{(W-1){1'b0}}, lt_unsigned};
            OP_AND:             y = a & b;
            OP_OR:              y = a | b;
            OP_XOR:             y = a ^ b;
            OP_UPPER:           y = b;
            default:            y = '0;
        endcase
    end
endmodule

// File: rtl/immop_alu.sv
module immop_alu
    import immop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [IDX_W-1:0]  dst_idx,
    output logic [DATA_W-1:0] res_q,
    output logic [IDX_W-1:0]  dst_q,
    output logic              wr_en_q,
    output logic              undef_q
);
    logic              dec_known;
    ext_mode_e         dec_mode;
    imm_op_e           dec_func;
    logic [DATA_W-1:0] ext_val;
    logic [DATA_W-1:0] core_y;
    stage_t            stage_d;
    stage_t            stage_q;

    immop_decode u_decode (
        .opcode   (op_code),
        .known    (dec_known),
        .ext_mode (dec_mode),
        .func     (dec_func)
    );

    immop_extend #(.W_IN(IMM_W), .W_OUT(DATA_W)) u_extend (
        .imm  (imm_field),
        .mode (dec_mode),
        .wide (ext_val)
    );

    immop_core #(.W(DATA_W)) u_core (
        .func (dec_func),
        .a    (src_val),
        .b    (ext_val),
        .y    (core_y)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.wr    = 1'b0;
        stage_d.undef = 1'b0;
        if (op_valid) begin
            if (dec_known) begin
                stage_d.res = core_y;
                stage_d.dst = dst_idx;
                stage_d.wr  = (dst_idx != '0);
            end else begin
                stage_d.undef = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign res_q   = stage_q.res;
    assign dst_q   = stage_q.dst;
    assign wr_en_q = stage_q.wr;
    assign undef_q = stage_q.undef;

    a_r6_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> (dst_q != '0));

    a_r7_undef_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        undef_q |-> !wr_en_q);

    a_r7_undef_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code < 6'd8)) |=> (undef_q && $stable(res_q)));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!wr_en_q && !undef_q && $stable(res_q)));

    a_r5_upper_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 6'd15) |=> (res_q[15:0] == 16'h0));

    a_r2_flag_only_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 6'd10 || op_code == 6'd11)) |=> (res_q[DATA_W-1:1] == '0));
endmodule

// File: tb/immop_alu_bench.sv
module immop_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [5:0]  op_code = '0;
    logic [31:0] src_val = '0;
    logic [15:0] imm_field = '0;
    logic [4:0]  dst_idx = '0;
    logic [31:0] res_q;
    logic [4:0]  dst_q;
    logic        wr_en_q;
    logic        undef_q;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] last_res = '0;
    logic [4:0]  last_dst = '0;

    always #4 clk = ~clk;

    immop_alu u_immop_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .src_val(src_val), .imm_field(imm_field), .dst_idx(dst_idx),
        .res_q(res_q), .dst_q(dst_q), .wr_en_q(wr_en_q), .undef_q(undef_q)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [5:0] op, input logic [31:0] a, input logic [15:0] im);
        logic [31:0] sx = {{16{im[15]}}, im};
        logic [31:0] zx = {16'h0, im};
        case (op)
            6'd8, 6'd9: return a + sx;
            6'd10:      return ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
            6'd11:      return (a < sx) ? 32'd1 : 32'd0;
            6'd12:      return a & zx;
            6'd13:      return a | zx;
            6'd14:      return a ^ zx;
            6'd15:      return {im, 16'h0};
            default:    return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] op);
        if (op == 6'd8 || op == 6'd9) return "R1";
        if (op == 6'd10) return "R2";
        if (op == 6'd11) return "R3";
        if (op >= 6'd12 && op <= 6'd14) return "R4";
        if (op == 6'd15) return "R5";
        return "R7";
    endfunction

    task automatic issue(input logic [5:0] op, input logic [31:0] a, input logic [15:0] im, input logic [4:0] d);
        logic defined = (op >= 6'd8 && op <= 6'd15);
        logic [31:0] exp_res;
        string t = tag_of(op);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; src_val = a; imm_field = im; dst_idx = d;
        @(negedge clk);
        op_valid = 1'b0;
        if (defined) begin
            exp_res = model(op, a, im);
            check(res_q == exp_res, t, res_q, exp_res);
            check(wr_en_q == (d != 0) && !undef_q && dst_q == d,
                  (d == 0) ? "R6" : t, {30'h0, wr_en_q, undef_q}, {30'h0, d != 0, 1'b0});
            last_res = exp_res; last_dst = d;
        end else begin
            check(undef_q && !wr_en_q, "R7", {30'h0, wr_en_q, undef_q}, 32'h1);
            check(res_q == last_res && dst_q == last_dst, "R7", res_q, last_res);
        end
    endtask

    logic [31:0] rs_pat [8] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                                32'hFFFFFFFF, 32'h12345678, 32'hFFFF8000, 32'h00007FFF};
    logic [15:0] im_pat [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                16'hFFFF, 16'h1234, 16'h8001, 16'h00FF};

    initial begin
        repeat (3) @(negedge clk);
        check(res_q == 0 && dst_q == 0 && !wr_en_q && !undef_q, "R9", res_q, 32'h0);
        rst_n = 1'b1;

        for (int op = 0; op < 64; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    issue(6'(op), rs_pat[i], im_pat[j], 5'(1 + ((i + j) % 31)));

        // R1 wraparound with no flag
        issue(6'd8, 32'h7FFFFFFF, 16'h0001, 5'd4);
        check(res_q == 32'h80000000 && !undef_q, "R1", res_q, 32'h80000000);
        // R3 negative immediate as large unsigned bound
        issue(6'd11, 32'h80000000, 16'h8000, 5'd5);
        check(res_q == 32'd1, "R3", res_q, 32'd1);
        // R5 source ignored
        issue(6'd15, 32'hDEADBEEF, 16'hA5A5, 5'd6);
        check(res_q == 32'hA5A50000, "R5", res_q, 32'hA5A50000);
        // R6 destination zero
        issue(6'd13, 32'h0, 16'h00FF, 5'd0);
        check(!wr_en_q, "R6", {31'h0, wr_en_q}, 32'h0);
        // R7 flag lasts one cycle
        issue(6'd63, 32'h1, 16'h1, 5'd7);
        @(negedge clk);
        check(!undef_q && !wr_en_q, "R7", {30'h0, wr_en_q, undef_q}, 32'h0);
        // R8 idle holds result
        issue(6'd12, 32'hFFFFFFFF, 16'hF0F0, 5'd9);
        @(negedge clk);
        check(!wr_en_q && !undef_q && res_q == 32'h0000F0F0, "R8", res_q, 32'h0000F0F0);
        @(negedge clk);
        check(res_q == 32'h0000F0F0 && dst_q == 5'd9, "R8", res_q, 32'h0000F0F0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule